// File: doc/BRIEF.md
# Cache Performance Counter Bank

This block holds the performance counters of one shared cache cluster: eight 32-bit event counters and one 64-bit cycle counter. Software reaches every register through an indirect pair. A write on the select path latches a 12-bit register address, and the data path then reads or writes the register at that address. Counting is gated twice: by a global run bit in the control register, and by a per-counter enable bit.

Enable, interrupt-enable and overflow status are each held in one 32-bit mask that is reached through two addresses. One address sets the bits written as one, and the other clears them. In every mask the event counters use the low bits and the cycle counter uses bit 31. When a counter rolls over from all ones to zero, its overflow bit is latched. A single interrupt line stays high while a latched overflow has its interrupt enabled. Event pulses come from an external selector, one line per counter.

Top module: `cache_pmu_bank`

## Requirements
- R1: A pulse on `sel_wr` latches `wr_data[11:0]` as the selected address. `rd_data` always shows the register at the selected address, and `data_wr` writes `wr_data` into it. Unmapped addresses read as zero.
- R2: The control register is at 0x400. A write sets the global run bit from bit 0, and if bit 1 or bit 2 is one it zeroes every counter, so 0x6 stops counting and clears. A read returns the run bit in bit 0 and the event counter count (8) in bits [15:11].
- R3: The mask pairs (set/clear) are: enable 0x404/0x403, interrupt enable 0x406/0x405, overflow 0x408/0x407. Ones written to a set address are ORed in, and ones written to a clear address are removed; zero bits leave state unchanged. Both addresses of a pair read the mask. Only bits [7:0] and 31 can hold a one.
- R4: Event counter n is read and written at 0x421+0x10·n. It adds one on a cycle where `evt_pulse[n]` is high, the run bit is set and enable bit n is set; otherwise it holds.
- R5: The 64-bit cycle counter is read and written at 0x40A. It adds one every cycle while the run bit and enable bit 31 are set.
- R6: A data write to a counter address loads that counter even if it increments in the same cycle. A clearing control write beats both.
- R7: A counter that rolls over from all ones to zero sets its overflow bit (n, or 31 for the cycle counter). This happens even if the same cycle writes a clear of that bit.
- R8: `irq` is high exactly while some overflow bit is set whose interrupt-enable bit is also set.
- R9: The per-counter control words at 0x409 (cycle) and 0x420+0x10·n (events) store 32 bits and read back. They do not affect counting.
- R10: After reset all counters, masks, control words, the run bit and the select register are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Latch `wr_data[11:0]` as the selected address |
| data_wr | input | 1 | Write `wr_data` to the selected register |
| wr_data | input | 64 | Write data for select and data writes |
| evt_pulse | input | 8 | One increment request per event counter |
| rd_data | output | 64 | Contents of the selected register |
| irq | output | 1 | Enabled overflow pending |

## Verification
Two operations can land on a single edge: a counter rollover and a software write that touches the same state. The write may be an overflow-clear of that bit, a value load into the incrementing counter, or a clearing control write. The bench sets up each collision on purpose. It preloads a counter to all ones, keeps its pulse line high, and issues the conflicting data write on the edge where the counter rolls over. A behavioural reference model predicts the result and is compared on every cycle, and directed reads confirm that the overflow bit survives and that the loaded value replaced the increment.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;
    localparam int ADDR_W      = 12;
    localparam int MASK_W      = 32;
    localparam int CYC_BIT     = 31;
    localparam int CNT_FLD_LSB = 11;
    localparam int EVT_STRIDE  = 16;

    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h400;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 12'h403;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 12'h404;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 12'h405;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 12'h406;
    localparam logic [ADDR_W-1:0] A_OV_CLR  = 12'h407;
    localparam logic [ADDR_W-1:0] A_OV_SET  = 12'h408;
    localparam logic [ADDR_W-1:0] A_CYC_CTL = 12'h409;
    localparam logic [ADDR_W-1:0] A_CYC_VAL = 12'h40A;
    localparam int               A_EVT_CTL = 'h420;
    localparam int               A_EVT_VAL = 'h421;
endpackage

// File: rtl/cpmu_counter.sv
module cpmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (ld)
            cnt_d = ld_val;
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // a rollover only counts when the increment actually takes effect
    assign wrap = inc & ~clr & ~ld & (&cnt_q);
    assign cnt  = cnt_q;
endmodule

// File: rtl/cpmu_decode.sv
module cpmu_decode
    import cpmu_pkg::*;
#(
    parameter int N_EVT = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ctrl,
    output logic              hit_en_set,
    output logic              hit_en_clr,
    output logic              hit_ie_set,
    output logic              hit_ie_clr,
    output logic              hit_ov_set,
    output logic              hit_ov_clr,
    output logic              hit_cyc_ctl,
    output logic              hit_cyc_val,
    output logic [N_EVT-1:0]  hit_ev_ctl,
    output logic [N_EVT-1:0]  hit_ev_val
);
    assign hit_ctrl    = (addr == A_CTRL);
    assign hit_en_set  = (addr == A_EN_SET);
    assign hit_en_clr  = (addr == A_EN_CLR);
    assign hit_ie_set  = (addr == A_IE_SET);
    assign hit_ie_clr  = (addr == A_IE_CLR);
    assign hit_ov_set  = (addr == A_OV_SET);
    assign hit_ov_clr  = (addr == A_OV_CLR);
    assign hit_cyc_ctl = (addr == A_CYC_CTL);
    assign hit_cyc_val = (addr == A_CYC_VAL);

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt_dec
        assign hit_ev_ctl[g] = (addr == ADDR_W'(A_EVT_CTL + g * EVT_STRIDE));
        assign hit_ev_val[g] = (addr == ADDR_W'(A_EVT_VAL + g * EVT_STRIDE));
    end
endmodule

// File: rtl/cache_pmu_bank.sv
module cache_pmu_bank
    import cpmu_pkg::*;
#(
    parameter int N_EVT  = 8,
    parameter int EVT_W  = 32,
    parameter int CYC_W  = 64,
    parameter int CTL_W  = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_EVT-1:0]  evt_pulse,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [MASK_W-1:0] VALID_MASK =
        (MASK_W'(1) << CYC_BIT) | ((MASK_W'(1) << N_EVT) - MASK_W'(1));
    localparam logic [4:0] CNT_FIELD = 5'(N_EVT);

    typedef struct packed {
        logic                         glob_en;
        logic [MASK_W-1:0]            en;
        logic [MASK_W-1:0]            ie;
        logic [MASK_W-1:0]            ovf;
        logic [ADDR_W-1:0]            sel;
        logic [CTL_W-1:0]             cyc_ctl;
        logic [N_EVT-1:0][CTL_W-1:0]  ev_ctl;
    } state_t;

    state_t r_d, r_q;

    logic hit_ctrl, hit_en_set, hit_en_clr, hit_ie_set, hit_ie_clr;
    logic hit_ov_set, hit_ov_clr, hit_cyc_ctl, hit_cyc_val;
    logic [N_EVT-1:0] hit_ev_ctl, hit_ev_val;

    cpmu_decode #(.N_EVT(N_EVT)) u_dec (
        .addr        (r_q.sel),
        .hit_ctrl    (hit_ctrl),
        .hit_en_set  (hit_en_set),
        .hit_en_clr  (hit_en_clr),
        .hit_ie_set  (hit_ie_set),
        .hit_ie_clr  (hit_ie_clr),
        .hit_ov_set  (hit_ov_set),
        .hit_ov_clr  (hit_ov_clr),
        .hit_cyc_ctl (hit_cyc_ctl),
        .hit_cyc_val (hit_cyc_val),
        .hit_ev_ctl  (hit_ev_ctl),
        .hit_ev_val  (hit_ev_val)
    );

    // counters
    logic                         clr_all;
    logic [N_EVT-1:0]             ev_inc, ev_wrap;
    logic [N_EVT-1:0][EVT_W-1:0]  ev_cnt;
    logic                         cyc_inc, cyc_wrap;
    logic [CYC_W-1:0]             cyc_cnt;
    logic [MASK_W-1:0]            wrap_vec;

    assign clr_all = data_wr & hit_ctrl & (|wr_data[2:1]);
    assign cyc_inc = r_q.glob_en & r_q.en[CYC_BIT];

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        assign ev_inc[g] = r_q.glob_en & r_q.en[g] & evt_pulse[g];

        cpmu_counter #(.W(EVT_W)) u_evt_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_all),
            .ld     (data_wr & hit_ev_val[g]),
            .ld_val (wr_data[EVT_W-1:0]),
            .inc    (ev_inc[g]),
            .cnt    (ev_cnt[g]),
            .wrap   (ev_wrap[g])
        );
    end

    cpmu_counter #(.W(CYC_W)) u_cyc_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_all),
        .ld     (data_wr & hit_cyc_val),
        .ld_val (wr_data[CYC_W-1:0]),
        .inc    (cyc_inc),
        .cnt    (cyc_cnt),
        .wrap   (cyc_wrap)
    );

    always_comb begin
        wrap_vec               = '0;
        wrap_vec[N_EVT-1:0]    = ev_wrap;
        wrap_vec[CYC_BIT]      = cyc_wrap;
    end

    // next-state logic
    always_comb begin
        logic [MASK_W-1:0] wd;
        wd  = wr_data[MASK_W-1:0];
        r_d = r_q;

        if (sel_wr)
            r_d.sel = wr_data[ADDR_W-1:0];

        if (data_wr) begin
            if (hit_ctrl)    r_d.glob_en = wr_data[0];
            if (hit_en_set)  r_d.en  = r_q.en  | (wd & VALID_MASK);
            if (hit_en_clr)  r_d.en  = r_q.en  & ~wd;
            if (hit_ie_set)  r_d.ie  = r_q.ie  | (wd & VALID_MASK);
            if (hit_ie_clr)  r_d.ie  = r_q.ie  & ~wd;
            if (hit_ov_set)  r_d.ovf = r_q.ovf | (wd & VALID_MASK);
            if (hit_ov_clr)  r_d.ovf = r_q.ovf & ~wd;
            if (hit_cyc_ctl) r_d.cyc_ctl = wr_data[CTL_W-1:0];
            for (int i = 0; i < N_EVT; i++) begin
                if (hit_ev_ctl[i]) r_d.ev_ctl[i] = wr_data[CTL_W-1:0];
            end
        end

        // a rollover on the same edge as a clear still leaves its bit set
        r_d.ovf = r_d.ovf | wrap_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    // read path
    always_comb begin
        rd_data = '0;
        if (hit_ctrl) begin
            rd_data[0]                         = r_q.glob_en;
            rd_data[CNT_FLD_LSB +: 5]          = CNT_FIELD;
        end
        if (hit_en_set || hit_en_clr) rd_data[MASK_W-1:0] = r_q.en;
        if (hit_ie_set || hit_ie_clr) rd_data[MASK_W-1:0] = r_q.ie;
        if (hit_ov_set || hit_ov_clr) rd_data[MASK_W-1:0] = r_q.ovf;
        if (hit_cyc_ctl)              rd_data[CTL_W-1:0]  = r_q.cyc_ctl;
        if (hit_cyc_val)              rd_data[CYC_W-1:0]  = cyc_cnt;
        for (int i = 0; i < N_EVT; i++) begin
            if (hit_ev_ctl[i]) rd_data[CTL_W-1:0] = r_q.ev_ctl[i];
            if (hit_ev_val[i]) rd_data[EVT_W-1:0] = ev_cnt[i];
        end
    end

    assign irq = |(r_q.ovf & r_q.ie);
endmodule

// File: rtl/cpmu_checker.sv
module cpmu_checker #(
    parameter int N_EVT = 8,
    parameter int EVT_W = 32,
    parameter int CYC_W = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   data_wr,
    input logic                   irq,
    input logic                   glob_en,
    input logic [31:0]            en,
    input logic [31:0]            ovf,
    input logic [CYC_W-1:0]       cyc,
    input logic [N_EVT*EVT_W-1:0] evts
);
    localparam logic [31:0] LEGAL = (32'(1) << 31) | ((32'(1) << N_EVT) - 32'(1));

    p_cyc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && en[31] && !data_wr) |=> (cyc == $past(cyc) + CYC_W'(1)));

    p_evt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !data_wr) |=> $stable(evts));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr) |=> ((ovf & $past(ovf)) == $past(ovf)));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf != 32'd0));

    p_mask_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & ~LEGAL) == 32'd0) && ((ovf & ~LEGAL) == 32'd0));
endmodule

bind cache_pmu_bank cpmu_checker #(.N_EVT(N_EVT), .EVT_W(EVT_W), .CYC_W(CYC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_wr (data_wr),
    .irq     (irq),
    .glob_en (r_q.glob_en),
    .en      (r_q.en),
    .ovf     (r_q.ovf),
    .cyc     (cyc_cnt),
    .evts    (ev_cnt)
);

// File: tb/test_cache_pmu_bank.sv
module test_cache_pmu_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic        data_wr = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  evt_pulse = '0;
    logic [63:0] rd_data;
    logic        irq;

    always #10 clk = ~clk;

    cache_pmu_bank i_cache_pmu_bank (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .data_wr(data_wr),
        .wr_data(wr_data), .evt_pulse(evt_pulse), .rd_data(rd_data), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit rnd_on = 0;
    logic [7:0] pulse_fix = '0;

    // reference model state
    bit              m_glob;
    bit [31:0]       m_en, m_ie, m_ovf, m_cctl;
    bit [11:0]       m_sel;
    longint unsigned m_cyc;
    int unsigned     m_ev[8];
    int unsigned     m_ctl[8];
    localparam bit [31:0] LEGAL = 32'h8000_00FF;

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic bit [63:0] m_read();
        bit [63:0] v = '0;
        case (m_sel)
            12'h400: v = 64'(8 << 11) | 64'(m_glob);
            12'h403, 12'h404: v = 64'(m_en);
            12'h405, 12'h406: v = 64'(m_ie);
            12'h407, 12'h408: v = 64'(m_ovf);
            12'h409: v = 64'(m_cctl);
            12'h40A: v = m_cyc;
            default: begin
                for (int i = 0; i < 8; i++) begin
                    if (m_sel == 12'(32'h420 + 16 * i)) v = 64'(m_ctl[i]);
                    if (m_sel == 12'(32'h421 + 16 * i)) v = 64'(m_ev[i]);
                end
            end
        endcase
        return v;
    endfunction

    function automatic string tag_of(bit [11:0] a);
        if (a == 12'h400) return "R2";
        if (a >= 12'h403 && a <= 12'h406) return "R3";
        if (a == 12'h407 || a == 12'h408) return "R7";
        if (a == 12'h409) return "R9";
        if (a == 12'h40A) return "R5";
        if (a >= 12'h420 && a <= 12'h497 && a[3:0] == 4'h0) return "R9";
        if (a >= 12'h421 && a <= 12'h497 && a[3:0] == 4'h1) return "R4";
        return "R1";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_glob = 0; m_en = 0; m_ie = 0; m_ovf = 0; m_cctl = 0; m_sel = 0; m_cyc = 0;
            for (int i = 0; i < 8; i++) begin m_ev[i] = 0; m_ctl[i] = 0; end
        end else begin
            bit        clr_all;
            bit [31:0] wraps;
            bit [31:0] wd;
            wd      = wr_data[31:0];
            wraps   = 0;
            clr_all = data_wr && m_sel == 12'h400 && wr_data[2:1] != 0;
            for (int i = 0; i < 8; i++) begin
                if (clr_all) m_ev[i] = 0;
                else if (data_wr && m_sel == 12'(32'h421 + 16 * i)) m_ev[i] = wd;
                else if (m_glob && m_en[i] && evt_pulse[i]) begin
                    if (m_ev[i] == 32'hFFFF_FFFF) wraps[i] = 1;
                    m_ev[i] = m_ev[i] + 1;
                end
            end
            if (clr_all) m_cyc = 0;
            else if (data_wr && m_sel == 12'h40A) m_cyc = wr_data;
            else if (m_glob && m_en[31]) begin
                if (m_cyc == 64'hFFFF_FFFF_FFFF_FFFF) wraps[31] = 1;
                m_cyc = m_cyc + 1;
            end
            if (data_wr) begin
                case (m_sel)
                    12'h400: m_glob = wr_data[0];
                    12'h404: m_en  = m_en  | (wd & LEGAL);
                    12'h403: m_en  = m_en  & ~wd;
                    12'h406: m_ie  = m_ie  | (wd & LEGAL);
                    12'h405: m_ie  = m_ie  & ~wd;
                    12'h408: m_ovf = m_ovf | (wd & LEGAL);
                    12'h407: m_ovf = m_ovf & ~wd;
                    12'h409: m_cctl = wd;
                    default: for (int i = 0; i < 8; i++)
                        if (m_sel == 12'(32'h420 + 16 * i)) m_ctl[i] = wd;
                endcase
            end
            m_ovf = m_ovf | wraps;
            if (sel_wr) m_sel = wr_data[11:0];
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag_of(m_sel), rd_data, m_read());
            chk("R8", 64'(irq), 64'((m_ovf & m_ie) != 0));
        end
    end

    task automatic tick();
        evt_pulse = rnd_on ? 8'($urandom) : pulse_fix;
        @(negedge clk);
    endtask

    task automatic wsel(bit [11:0] a);
        sel_wr = 1; wr_data = 64'(a);
        tick();
        sel_wr = 0;
    endtask

    task automatic wdat(bit [63:0] v);
        data_wr = 1; wr_data = v;
        tick();
        data_wr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R10: reset state
        chk("R10", 64'(irq), 64'd0);
        chk("R10", rd_data, 64'd0);
        wsel(12'h400);
        chk("R2", rd_data, 64'h4000);
        wsel(12'h7FF);
        chk("R1", rd_data, 64'd0);
        // R3: set/clear masks
        wsel(12'h404);
        wdat(64'hFFFF_FFFF);
        chk("R3", rd_data, 64'h8000_00FF);
        wsel(12'h403);
        wdat(64'h5);
        chk("R3", rd_data, 64'h8000_00FA);
        wsel(12'h404);
        chk("R3", rd_data, 64'h8000_00FA);
        wdat(64'hFFFF_FFFF);
        // R9: control words
        wsel(12'h409);
        wdat(64'h1234_5678);
        chk("R9", rd_data, 64'h1234_5678);
        wsel(12'h450);
        wdat(64'hA5A5);
        chk("R9", rd_data, 64'hA5A5);
        // R6: load while idle
        wsel(12'h441);
        wdat(64'hFFFF_FFF8);
        chk("R6", rd_data, 64'hFFFF_FFF8);
        wsel(12'h406);
        wdat(64'hFFFF_FFFF);
        // random counting
        wsel(12'h400);
        wdat(64'h1);
        rnd_on = 1;
        wsel(12'h441);
        repeat (40) tick();
        wsel(12'h408);
        repeat (4) tick();
        rnd_on = 0;
        pulse_fix = 0;
        // R7: rollover and overflow clear on the same edge
        wsel(12'h421);
        wdat(64'hFFFF_FFFF);
        wsel(12'h407);
        wdat(64'h1);
        data_wr = 1; wr_data = 64'h1; pulse_fix = 8'h01;
        tick();
        data_wr = 0; pulse_fix = 0;
        wsel(12'h408);
        chk("R7", 64'(rd_data[0]), 64'd1);
        chk("R8", 64'(irq), 64'd1);
        // R6: load beats increment
        pulse_fix = 8'h02;
        wsel(12'h431);
        wdat(64'd100);
        chk("R6", rd_data, 64'd100);
        tick();
        chk("R4", rd_data, 64'd101);
        pulse_fix = 0;
        // R5: cycle counter rollover
        wsel(12'h40A);
        wdat(64'hFFFF_FFFF_FFFF_FFFD);
        chk("R5", rd_data, 64'hFFFF_FFFF_FFFF_FFFD);
        repeat (3) tick();
        chk("R5", rd_data, 64'd0);
        wsel(12'h408);
        chk("R7", 64'(rd_data[31]), 64'd1);
        // R2: clear-all and stop
        wsel(12'h400);
        wdat(64'h6);
        chk("R2", rd_data, 64'h4000);
        wsel(12'h40A);
        chk("R2", rd_data, 64'd0);
        // R4: no counting while stopped
        pulse_fix = 8'hFF;
        wsel(12'h421);
        repeat (5) tick();
        chk("R4", rd_data, 64'd0);
        pulse_fix = 0;
        // R8: clearing all overflow drops irq
        wsel(12'h407);
        wdat(64'hFFFF_FFFF);
        chk("R8", 64'(irq), 64'd0);
        chk("R7", rd_data, 64'd0);
        tick();
        done = 1;
        summary();
        $finish;
    end
endmodule